// File: doc/BRIEF.md
# Serial ADC Interface and Conversion Sequencer

This block is the digital controller of an eight-input, 10-bit successive-approximation converter that is driven over a serial link. A host clocks a short command onto the data input. The first three bits pick the input channel, most significant bit first. The fourth bit picks how the result of the conversion being started will be framed. While the command goes in, the result of the previous conversion comes out on the data output, one bit per falling serial-clock edge. A data-output enable tells the pad when to drive. All other times the pad stays in high impedance.

After the command, a sampling window opens on the selected channel. Once the window has closed and the outgoing word has been fully clocked out, the block runs the successive-approximation search. The search presents trial codes to an external comparator and holds a busy status for a fixed number of conversion-clock periods. Both the serial clock and the conversion clock arrive as single-cycle enable strobes, and everything runs in one system clock domain. A result is delivered once: the exchange that reads it also starts the next conversion.

Top module: `adc_serial_seq`

## Requirements
- R1: While `cs_n` is low, each `sclk_rise` strobe takes one bit from `din`. The first three bits form the channel number, first bit = bit 2. `chan_sel` takes the new number on the third strobe and holds its old value before that strobe.
- R2: `dout_en` is 1 exactly when `cs_n` and `oe_n` are both 0. The output word advances only on `sclk_fall` strobes that come while both are 0.
- R3: With framing bit 0, the word reads out as D9 down to D0 (10 bits). With framing bit 1, six 0 bits come first and then D9 down to D0 (16 bits). The first bit is visible before the first rising strobe of the exchange.
- R4: `sample_en` goes high on the fourth rising strobe of the exchange. It stays high for nine more serial edges, rising and falling, so it drops on the eighth falling strobe. It is never high while `busy` is high.
- R5: `busy` rises only after the sampling window has closed and the previous word has been clocked out in full: 10 falling strobes for framing 0, 16 for framing 1. `busy` then stays high for exactly 41 `conv_tick` strobes.
- R6: While `busy` is high, an enabled `dout` reads 0. In the cycle after `busy` falls, `dout` already shows the first bit of the new word: 0 for framing 1, D9 for framing 0.
- R7: Raising `cs_n` during a conversion sets `dout_en` to 0. The conversion still completes with the same 41-strobe length and the same result.
- R8: `dout_valid` is 0 from reset until the first conversion ends. After that it is 1 from the cycle `busy` falls until the next conversion starts, because a result can be read only once.
- R9: The search resolves one bit per `conv_tick`, starting at the most significant bit. Each trial bit is kept when `cmp_in` is 1. With a comparator that returns 1 when `dac_code` is at most the input code, the result equals that input code.
- R10: After reset, `busy`, `sample_en`, `dout_valid`, `chan_sel` and the enabled `dout` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| sclk_rise | input | 1 | Strobe: rising serial-clock edge |
| sclk_fall | input | 1 | Strobe: falling serial-clock edge |
| conv_tick | input | 1 | Strobe: one conversion-clock period |
| cs_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low |
| din | input | 1 | Serial command input |
| cmp_in | input | 1 | Comparator decision, 1 = keep trial bit |
| chan_sel | output | 3 | Selected analog channel |
| sample_en | output | 1 | Sampling window open |
| busy | output | 1 | Conversion in progress |
| dac_code | output | 10 | Trial code presented to the comparator |
| dout | output | 1 | Serial result output |
| dout_en | output | 1 | Drive enable for the data-output pad |
| dout_valid | output | 1 | Output word holds an unread result |

## Verification
The hardest condition to reach is the overlap of one conversion's tail with the next exchange. The word being read was framed by the previous command, while the framing bit now arriving applies only to the next word. Because of this, a 16-bit exchange must follow each right-justified command. The stimulus chains seeded random channels, input codes and framing bits. Each read therefore checks the earlier conversion, while the new command switches framing under it. Directed passes at codes 0, 1, 511, 512 and 1023 cover the extremes. Some passes raise chip select during the conversion, and some hold output enable off for a whole exchange.

// File: rtl/adcseq_pkg.sv
package adcseq_pkg;

    localparam int RES_BITS    = 10;
    localparam int CHAN_BITS   = 3;
    localparam int FRAME_BITS  = 16;
    localparam int CONV_PERIOD = 41;
    localparam int ACQ_EDGES   = 9;

    typedef enum logic [1:0] {
        PH_ADDR = 2'd0,
        PH_ACQ  = 2'd1,
        PH_CONV = 2'd2
    } phase_t;

endpackage

// File: rtl/adcseq_addr_rx.sv
module adcseq_addr_rx #(
    parameter int CH_W = 3
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            clr,
    input  logic            shift_en,
    input  logic            din,
    output logic [CH_W-1:0] chan_sel,
    output logic            rjust,
    output logic            addr_last,
    output logic            any_bit
);
    localparam int NB = CH_W + 1;
    localparam int CW = $clog2(NB + 1);
    localparam logic [CW-1:0] IDX_CHAN = CW'(CH_W - 1);
    localparam logic [CW-1:0] IDX_JUST = CW'(CH_W);
    localparam logic [CW-1:0] IDX_END  = CW'(NB);

    logic [CW-1:0]   nbits;
    logic [CH_W-1:0] sr;

    assign addr_last = shift_en && (nbits == IDX_JUST);
    assign any_bit   = (nbits != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            nbits    <= '0;
            sr       <= '0;
            chan_sel <= '0;
            rjust    <= 1'b0;
        end else if (clr) begin
            nbits <= '0;
            sr    <= '0;
        end else if (shift_en && nbits != IDX_END) begin
            nbits <= nbits + 1'b1;
            if (nbits < IDX_JUST)
                sr <= {sr[CH_W-2:0], din};
            if (nbits == IDX_CHAN)
                chan_sel <= {sr[CH_W-2:0], din};
            if (nbits == IDX_JUST)
                rjust <= din;
        end
    end

    // R1: channel select moves only on an accepted rising strobe
    a_r1_chan_on_strobe: assert property (@(posedge clk) disable iff (rst)
        !$stable(chan_sel) |-> $past(shift_en));

endmodule

// File: rtl/adcseq_sar.sv
module adcseq_sar #(
    parameter int RES_W      = 10,
    parameter int CONV_TICKS = 41
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             tick,
    input  logic             cmp_in,
    output logic             busy,
    output logic             finish,
    output logic [RES_W-1:0] code
);
    localparam int CW = $clog2(CONV_TICKS);
    localparam logic [CW-1:0] LAST    = CW'(CONV_TICKS - 1);
    localparam logic [CW-1:0] RES_CNT = CW'(RES_W);

    logic [CW-1:0]    cnt;
    logic [RES_W-1:0] trial_nxt;

    always_comb begin
        trial_nxt = code;
        for (int i = 0; i < RES_W; i++) begin
            if (cnt == CW'(RES_W - 1 - i))
                trial_nxt[i] = cmp_in;
        end
        for (int i = 0; i < RES_W - 1; i++) begin
            if (cnt == CW'(RES_W - 2 - i))
                trial_nxt[i] = 1'b1;
        end
    end

    assign finish = busy && tick && (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            cnt  <= '0;
            code <= '0;
        end else if (start && !busy) begin
            busy <= 1'b1;
            cnt  <= '0;
            code <= {1'b1, {(RES_W-1){1'b0}}};
        end else if (busy && tick) begin
            if (cnt < RES_CNT)
                code <= trial_nxt;
            if (cnt == LAST)
                busy <= 1'b0;
            else
                cnt <= cnt + 1'b1;
        end
    end

    // R9: search opens with only the most significant trial bit set
    a_r9_msb_trial: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> code == {1'b1, {(RES_W-1){1'b0}}});

    // R9: every bit is resolved before busy drops
    a_r9_settled: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> $stable(code));

endmodule

// File: rtl/adcseq_txreg.sv
module adcseq_txreg #(
    parameter int RES_W   = 10,
    parameter int FRAME_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             load_rj,
    input  logic [RES_W-1:0] load_val,
    input  logic             edge_cnt_en,
    input  logic             shift_en,
    output logic             msb,
    output logic             done
);
    localparam int PAD = FRAME_W - RES_W;
    localparam int CW  = $clog2(FRAME_W + 1);
    localparam logic [CW-1:0] LEN_L = CW'(RES_W);
    localparam logic [CW-1:0] LEN_R = CW'(FRAME_W);

    logic [FRAME_W-1:0] shreg;
    logic [CW-1:0]      cnt;
    logic               rj_cur;
    logic [FRAME_W-1:0] frame_l, frame_r;

    assign frame_l = {load_val, {PAD{1'b0}}};
    assign frame_r = {{PAD{1'b0}}, load_val};
    assign msb     = shreg[FRAME_W-1];
    assign done    = (cnt >= (rj_cur ? LEN_R : LEN_L));

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg  <= '0;
            cnt    <= '0;
            rj_cur <= 1'b0;
        end else if (load) begin
            shreg  <= load_rj ? frame_r : frame_l;
            cnt    <= '0;
            rj_cur <= load_rj;
        end else begin
            if (edge_cnt_en && !done)
                cnt <= cnt + 1'b1;
            if (shift_en)
                shreg <= {shreg[FRAME_W-2:0], 1'b0};
        end
    end

endmodule

// File: rtl/adc_serial_seq.sv
module adc_serial_seq
    import adcseq_pkg::*;
#(
    parameter int CH_W       = CHAN_BITS,
    parameter int RES_W      = RES_BITS,
    parameter int FRAME_W    = FRAME_BITS,
    parameter int CONV_TICKS = CONV_PERIOD,
    parameter int WIN_EDGES  = ACQ_EDGES
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sclk_rise,
    input  logic             sclk_fall,
    input  logic             conv_tick,
    input  logic             cs_n,
    input  logic             oe_n,
    input  logic             din,
    input  logic             cmp_in,
    output logic [CH_W-1:0]  chan_sel,
    output logic             sample_en,
    output logic             busy,
    output logic [RES_W-1:0] dac_code,
    output logic             dout,
    output logic             dout_en,
    output logic             dout_valid
);
    localparam int WW = $clog2(WIN_EDGES + 1);
    localparam logic [WW-1:0] WIN_END = WW'(WIN_EDGES);

    phase_t        phase;
    logic [WW-1:0] win_cnt;
    logic          sel;
    logic          addr_shift, addr_clr, addr_last, any_bit, rjust;
    logic          fall_cnt_en, tx_shift, tx_done, tx_msb;
    logic          win_edge, start, finish;

    assign sel        = !cs_n;
    assign addr_shift = (phase == PH_ADDR) && sel && sclk_rise;
    assign addr_clr   = finish || ((phase == PH_ADDR) && cs_n);
    assign fall_cnt_en = sel && sclk_fall &&
                         ((phase == PH_ACQ) || ((phase == PH_ADDR) && any_bit));
    assign tx_shift   = fall_cnt_en && !oe_n;
    assign win_edge   = (phase == PH_ACQ) && sel && (sclk_rise || sclk_fall) &&
                        (win_cnt != WIN_END);
    assign start      = (phase == PH_ACQ) && (win_cnt == WIN_END) && tx_done;
    assign sample_en  = (phase == PH_ACQ) && (win_cnt != WIN_END);
    assign dout_en    = !cs_n && !oe_n;
    assign dout       = dout_en && !busy && tx_msb;

    adcseq_addr_rx #(.CH_W(CH_W)) u_addr (
        .clk(clk), .rst(rst), .clr(addr_clr), .shift_en(addr_shift), .din(din),
        .chan_sel(chan_sel), .rjust(rjust), .addr_last(addr_last), .any_bit(any_bit)
    );

    adcseq_sar #(.RES_W(RES_W), .CONV_TICKS(CONV_TICKS)) u_sar (
        .clk(clk), .rst(rst), .start(start), .tick(conv_tick), .cmp_in(cmp_in),
        .busy(busy), .finish(finish), .code(dac_code)
    );

    adcseq_txreg #(.RES_W(RES_W), .FRAME_W(FRAME_W)) u_tx (
        .clk(clk), .rst(rst), .load(finish), .load_rj(rjust), .load_val(dac_code),
        .edge_cnt_en(fall_cnt_en), .shift_en(tx_shift), .msb(tx_msb), .done(tx_done)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            phase      <= PH_ADDR;
            win_cnt    <= '0;
            dout_valid <= 1'b0;
        end else begin
            unique case (phase)
                PH_ADDR: if (addr_last) begin
                    phase   <= PH_ACQ;
                    win_cnt <= '0;
                end
                PH_ACQ: begin
                    if (win_edge)
                        win_cnt <= win_cnt + 1'b1;
                    if (start)
                        phase <= PH_CONV;
                end
                PH_CONV: if (finish)
                    phase <= PH_ADDR;
                default: phase <= PH_ADDR;
            endcase
            if (finish)
                dout_valid <= 1'b1;
            else if (start)
                dout_valid <= 1'b0;
        end
    end

    // R4: sampling window and conversion never overlap
    a_r4_no_overlap: assert property (@(posedge clk) disable iff (rst)
        !(sample_en && busy));

    // R5: conversion begins only after window closed and word drained
    a_r5_start_gate: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(tx_done && win_cnt == WIN_END));

    // R8: a finished conversion leaves an unread result behind
    a_r8_valid_on_done: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> dout_valid);

    // R7: chip select cannot cut a conversion short
    a_r7_conv_holds: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> phase == PH_CONV);

endmodule

// File: tb/sim_adc_serial_seq.sv
module sim_adc_serial_seq;
    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    logic sclk_rise = 0, sclk_fall = 0, conv_tick = 0;
    logic cs_n = 0, oe_n = 0, din = 0;
    logic [9:0] vin_code = '0;
    logic       cmp_in;
    logic [2:0] chan_sel;
    logic       sample_en, busy, dout, dout_en, dout_valid;
    logic [9:0] dac_code;

    int errors = 0;
    int checks = 0;
    int busy_ticks = 0;

    assign cmp_in = (dac_code <= vin_code);

    adc_serial_seq u0 (
        .clk(clk), .rst(rst), .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
        .conv_tick(conv_tick), .cs_n(cs_n), .oe_n(oe_n), .din(din), .cmp_in(cmp_in),
        .chan_sel(chan_sel), .sample_en(sample_en), .busy(busy), .dac_code(dac_code),
        .dout(dout), .dout_en(dout_en), .dout_valid(dout_valid)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] frame_of(input logic [9:0] v, input logic rj);
        return rj ? {6'b0, v} : {v, 6'b0};
    endfunction

    initial begin
        forever begin
            repeat (2) @(negedge clk);
            conv_tick = 1'b1;
            if (busy) busy_ticks++;
            @(negedge clk);
            conv_tick = 1'b0;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog run did not finish actual=1 expected=0");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    task automatic wait_busy(input logic lvl);
        int n;
        n = 0;
        while (busy !== lvl && n < 3000) begin
            @(negedge clk);
            n++;
        end
        chk("R5", "busy level reached", int'(busy), int'(lvl));
    endtask

    task automatic exchange(input logic [2:0] a, input logic rj, input int nper,
                            output logic [15:0] got);
        logic [2:0] old;
        old = chan_sel;
        got = '0;
        for (int p = 0; p < nper; p++) begin
            logic d, b;
            d = (p < 3) ? a[2-p] : ((p == 3) ? rj : 1'b0);
            b = dout;
            din = d;
            sclk_rise = 1'b1;
            @(negedge clk);
            sclk_rise = 1'b0;
            if (p == 1) chk("R1", "chan_sel before third bit", int'(chan_sel), int'(old));
            if (p == 2) chk("R1", "chan_sel after third bit", int'(chan_sel), int'(a));
            @(negedge clk);
            sclk_fall = 1'b1;
            @(negedge clk);
            sclk_fall = 1'b0;
            @(negedge clk);
            got[15-p] = b;
            if (p <= 7)
                chk("R4", $sformatf("sample_en after period %0d", p),
                    int'(sample_en), int'(p >= 3 && p <= 6));
        end
    endtask

    initial begin
        logic [9:0]  prev_v;
        logic        prev_rj;
        bit          have_prev;
        int unsigned seed_v;
        logic [15:0] got;

        seed_v = $urandom(32'd2024);
        prev_v = '0;
        prev_rj = 1'b0;
        have_prev = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R10", "busy after reset", int'(busy), 0);
        chk("R10", "sample_en after reset", int'(sample_en), 0);
        chk("R10", "dout_valid after reset", int'(dout_valid), 0);
        chk("R10", "chan_sel after reset", int'(chan_sel), 0);
        chk("R10", "dout after reset", int'(dout), 0);
        chk("R2", "dout_en with cs and oe low", int'(dout_en), 1);
        cs_n = 1'b1;
        @(negedge clk);
        chk("R2", "dout_en with cs high", int'(dout_en), 0);
        cs_n = 1'b0;
        @(negedge clk);

        for (int it = 0; it < 24; it++) begin
            logic [2:0] a;
            logic       rj;
            logic [9:0] v;
            bit         cs_hi, oe_hi;
            a  = 3'($urandom % 8);
            rj = 1'($urandom % 2);
            v  = 10'($urandom % 1024);
            case (it)
                0: begin v = 10'd0;    rj = 1'b0; a = 3'd5; end
                1: begin v = 10'd1023; rj = 1'b1; a = 3'd2; end
                2: begin v = 10'd512;  rj = 1'b0; a = 3'd7; end
                3: begin v = 10'd511;  rj = 1'b1; a = 3'd0; end
                4: begin v = 10'd1;    rj = 1'b0; end
                default: ;
            endcase
            cs_hi = (it % 5 == 3);
            oe_hi = (it == 6 || it == 15);
            vin_code = v;
            busy_ticks = 0;
            chk("R8", "dout_valid before exchange", int'(dout_valid), int'(have_prev));
            if (oe_hi) begin
                oe_n = 1'b1;
                @(negedge clk);
                chk("R2", "dout_en with oe high", int'(dout_en), 0);
            end
            exchange(a, rj, prev_rj ? 16 : 10, got);
            oe_n = 1'b0;
            if (have_prev && !oe_hi)
                chk("R3 R9", "word read out", int'(got), int'(frame_of(prev_v, prev_rj)));
            wait_busy(1'b1);
            chk("R4", "sample_en during conversion", int'(sample_en), 0);
            repeat (20) @(negedge clk);
            if (cs_hi) begin
                cs_n = 1'b1;
                @(negedge clk);
                chk("R7", "dout_en with cs high in conversion", int'(dout_en), 0);
            end else begin
                chk("R6", "dout during conversion", int'(dout), 0);
            end
            wait_busy(1'b0);
            chk("R5", "conversion tick count", busy_ticks, 41);
            if (cs_hi) begin
                cs_n = 1'b0;
                @(negedge clk);
            end
            chk("R6", "first bit before any edge", int'(dout), rj ? 0 : int'(v[9]));
            chk("R8", "dout_valid after conversion", int'(dout_valid), 1);
            prev_v = v;
            prev_rj = rj;
            have_prev = 1'b1;
        end

        exchange(3'd4, 1'b0, prev_rj ? 16 : 10, got);
        chk("R3 R9", "final word read out", int'(got), int'(frame_of(prev_v, prev_rj)));
        wait_busy(1'b1);
        chk("R8", "dout_valid after final read", int'(dout_valid), 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule